// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits behind the bus front end of a 64K x16 flash memory and turns sequences of bus writes into flash commands. Each write event carries a word address and a data word. Each read request returns, one cycle later, one of four things: array contents, identification codes, a per-block protection flag, or a status word. Which one depends on the current mode. A guarded multi-write unlock prefix protects every state-changing command. A simulated program controller stays busy for a parameterised number of cycles after each program starts.

The address space is split into five blocks of unequal size, and each block has one bit in a protection vector. Programming can only clear bits. A bypass mode cuts programming down to two writes. Errors are sticky until a read/reset command clears them. To keep elaboration small, the array model stores 2^WIN_W words in each 4K-word region. A word's storage index is formed from A15..A12 followed by the low WIN_W address bits, so addresses that differ only in the bits between them share storage.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read mode. Every array word reads 0xFFFF. rd_data holds the value for a read request one clock after rd_en. Storage index is {addr[15:12], addr[WIN_W-1:0]}.
- R2: Only wr_data[7:0] takes part in command decoding, and wr_data[15:8] never changes a decision. Unlock addresses are compared on addr[10:0]: 0x555 for the first and third cycles, 0x2AA for the second.
- R3: A write that does not continue a valid sequence returns the block to read mode. This holds from auto-select mode too.
- R4: Read/reset is either one write of 0xF0 to any address, or the unlock pair 0xAA@0x555, 0x55@0x2AA followed by 0xF0@0x555. It clears a pending error.
- R5: The unlock pair followed by 0x90@0x555 enters auto-select mode, which persists until another command. In that mode a read with addr[1:0]=00 returns 0x0020 and a read with addr[1:0]=01 returns 0x0097.
- R6: In auto-select mode a read with addr[1:0]=10 returns 0x0001 if the block containing the address is protected, and 0x0000 otherwise. Protection bits map as follows: prot[0]=0000-1FFF, prot[1]=2000-2FFF, prot[2]=3000-3FFF, prot[3]=4000-7FFF, prot[4]=8000-FFFF.
- R7: The unlock pair, then 0xA0@0x555, then a data write programs that word with old AND data. If the target block is protected, the program is dropped: no busy period, no error, and the word is unchanged.
- R8: A program stays busy for BUSY_CYC cycles, and every write during that time is ignored. Reads during busy return the status word: bit7 = NOT data bit 7, bit6 toggles on every status read, bit5 = error, and all other bits are 0. On success the block returns to its mode.
- R9: A program whose data has a 1 where the stored word has a 0 is an error. After the busy period, reads keep returning status with bit5 set until a read/reset.
- R10: The unlock pair followed by 0x20@0x555 enters bypass mode. In bypass, 0xA0 to any address followed by a data write programs the word. Array reads work as in read mode, and every other write is ignored.
- R11: In bypass, 0x90 followed by 0x00 returns the block to read mode. A 0xF0 read/reset after an error leaves the block in bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write event |
| addr | input | 16 | Word address for write or read |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Bus read request |
| prot | input | 5 | Per-block protection vector |
| rd_data | output | 16 | Read result, registered |

## Verification
Programs are driven through both the four-write and the two-write forms, to random addresses and with random data and random protection vectors. This separates a correct AND-merge from a plain overwrite, and a protected drop from a real program. Command words carrying junk in the upper byte, malformed unlock cycles, and writes issued while busy each show whether a sequence was decoded, restarted or ignored. The ignored case is visible because auto-select or array data appears in place of the expected result. Error cases in read mode and in bypass mode separate a sticky error from a transient one, and show which mode each kind of reset returns to.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int          WIN_W    = 4,
  parameter int          BUSY_CYC = 8,
  parameter logic [15:0] MAKER_ID = 16'h0020,
  parameter logic [15:0] DEV_ID   = 16'h0097
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic [4:0]  prot,
  output logic [15:0] rd_data
);
  localparam int DEPTH = 16 << WIN_W;
  localparam int IW    = 4 + WIN_W;
  localparam int CW    = $clog2(BUSY_CYC + 1);

  typedef enum logic [1:0] {M_READ, M_AUTO, M_BYP} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_BPGM, S_BRST, S_BUSY, S_ERR} seq_t;

  mode_t mode;
  seq_t  seq;
  logic [CW-1:0] cnt;
  logic err, pdat7, tog;
  logic [15:0] mem [DEPTH];

  function automatic logic [2:0] blk_of(input logic [15:0] a);
    if (a[15])                 return 3'd4;
    else if (a[14])            return 3'd3;
    else if (a[13:12] == 2'b11) return 3'd2;
    else if (a[13:12] == 2'b10) return 3'd1;
    else                       return 3'd0;
  endfunction

  wire [7:0]    cmd      = wr_data[7:0];
  wire          at_a     = addr[10:0] == 11'h555;
  wire          at_b     = addr[10:0] == 11'h2AA;
  wire [IW-1:0] idx      = {addr[15:12], addr[WIN_W-1:0]};
  wire          tgt_prot = prot[blk_of(addr)];
  wire [15:0]   old      = mem[idx];
  wire          bad      = |(wr_data & ~old);
  wire          pgm_go   = wr_en && (seq == S_PGM || seq == S_BPGM) && !tgt_prot;
  wire          show_st  = seq == S_BUSY || seq == S_ERR;
  wire [15:0]   status   = {8'h00, ~pdat7, tog, err, 5'b0};

  logic [15:0] auto_val;
  always_comb
    case (addr[1:0])
      2'b00:   auto_val = MAKER_ID;
      2'b01:   auto_val = DEV_ID;
      2'b10:   auto_val = {15'b0, tgt_prot};
      default: auto_val = 16'h0000;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else if (pgm_go) begin
      mem[idx] <= old & wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode  <= M_READ;
      seq   <= S_IDLE;
      cnt   <= '0;
      err   <= 1'b0;
      pdat7 <= 1'b0;
    end else if (seq == S_BUSY) begin
      if (cnt == 0) seq <= err ? S_ERR : S_IDLE;
      else          cnt <= cnt - 1'b1;
    end else if (wr_en) begin
      case (seq)
        S_IDLE:
          if (mode == M_BYP) begin
            if (cmd == 8'hA0)      seq <= S_BPGM;
            else if (cmd == 8'h90) seq <= S_BRST;
          end else if (cmd == 8'hAA && at_a) seq <= S_U1;
          else mode <= M_READ;
        S_U1:
          if (cmd == 8'h55 && at_b) seq <= S_U2;
          else begin seq <= S_IDLE; mode <= M_READ; end
        S_U2: begin
          seq  <= S_IDLE;
          mode <= M_READ;
          if (at_a)
            case (cmd)
              8'h90: mode <= M_AUTO;
              8'h20: mode <= M_BYP;
              8'hA0: seq  <= S_PGM;
              default: ;
            endcase
        end
        S_PGM, S_BPGM: begin
          seq <= S_IDLE;
          if (!tgt_prot) begin
            seq   <= S_BUSY;
            cnt   <= CW'(BUSY_CYC - 1);
            err   <= bad;
            pdat7 <= wr_data[7];
          end
        end
        S_BRST: begin
          seq <= S_IDLE;
          if (cmd == 8'h00) mode <= M_READ;
        end
        S_ERR:
          if (cmd == 8'hF0) begin seq <= S_IDLE; err <= 1'b0; end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_data <= 16'h0000;
      tog     <= 1'b0;
    end else if (rd_en) begin
      if (show_st) begin
        rd_data <= status;
        tog     <= ~tog;
      end else if (mode == M_AUTO) rd_data <= auto_val;
      else                         rd_data <= old;
    end

  a_r8_busy_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_BUSY && cnt != 0) |=> (seq == S_BUSY && $stable(mode)));
  a_r8_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_BUSY) |-> (cnt < CW'(BUSY_CYC)));
  a_r7_protected_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (seq == S_PGM || seq == S_BPGM) && tgt_prot) |=> (seq == S_IDLE && !err));
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_ERR && !(wr_en && wr_data[7:0] == 8'hF0)) |=> (seq == S_ERR && err));
  a_r10_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BYP && seq == S_IDLE && wr_en) |=> (mode == M_BYP));
  a_r11_reset_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_ERR && wr_en && wr_data[7:0] == 8'hF0) |=> ($stable(mode) && seq == S_IDLE && !err));
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int WIN_W = 4;
  localparam int BUSY_CYC = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0, wr_data = '0;
  logic [4:0]  prot = '0;
  logic [15:0] rd_data;

  flash_cmd_seq #(.WIN_W(WIN_W), .BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .prot(prot), .rd_data(rd_data));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] model [16 << WIN_W];

  function automatic int mi(input logic [15:0] a);
    return int'({a[15:12], a[WIN_W-1:0]});
  endfunction
  function automatic int blk(input logic [15:0] a);
    if (a >= 16'h8000) return 4;
    if (a >= 16'h4000) return 3;
    if (a >= 16'h3000) return 2;
    if (a >= 16'h2000) return 1;
    return 0;
  endfunction
  function automatic logic [15:0] st_exp(input logic [15:0] d, input logic e, input logic t);
    return {8'h00, ~d[7], t, e, 5'b0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic unlock(input logic [7:0] c);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, {8'h00, c});
  endtask

  task automatic wait_busy();
    repeat (BUSY_CYC + 2) @(negedge clk);
  endtask

  function automatic logic model_pgm(input logic [15:0] a, input logic [15:0] d);
    logic e;
    if (prot[blk(a)]) return 1'b0;
    e = |(d & ~model[mi(a)]);
    model[mi(a)] = model[mi(a)] & d;
    return e;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v, v2, a, d;
    logic e;
    void'($urandom(32'd1234));
    for (int i = 0; i < (16 << WIN_W); i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(16'h1234, v); chk("R1 erased after reset", v, 16'hFFFF);
    rd(16'hFFFF, v); chk("R1 erased top word", v, 16'hFFFF);

    prot = 5'b10100;
    unlock(8'h90);
    rd(16'h0000, v); chk("R5 maker code", v, 16'h0020);
    rd(16'hF001, v); chk("R5 device code", v, 16'h0097);
    rd(16'h3002, v); chk("R6 prot block 3000", v, 16'h0001);
    rd(16'h2FFE, v); chk("R6 unprot block 2000", v, 16'h0000);
    rd(16'h9ABE, v); chk("R6 prot block 8000", v, 16'h0001);
    rd(16'h4002, v); chk("R6 unprot block 4000", v, 16'h0000);
    rd(16'h0004, v); chk("R5 mode persists", v, 16'h0020);
    wr(16'h0123, 16'h0077);
    rd(16'h0000, v); chk("R3 invalid write exits auto", v, 16'hFFFF);

    wr(16'h0555, 16'h12AA); wr(16'h02AA, 16'hFF55); wr(16'h0555, 16'h3490);
    rd(16'h0000, v); chk("R2 upper byte ignored on unlock", v, 16'h0020);
    wr(16'h7777, 16'hABF0);
    rd(16'h0000, v); chk("R2 R4 one-write reset", v, 16'hFFFF);
    unlock(8'h90);
    unlock(8'hF0);
    rd(16'h0000, v); chk("R4 three-write reset", v, 16'hFFFF);
    wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055); wr(16'h0555, 16'h0090);
    rd(16'h0000, v); chk("R3 bad second address", v, 16'hFFFF);

    prot = 5'b10000;
    unlock(8'hA0); wr(16'h4005, 16'h1234); e = model_pgm(16'h4005, 16'h1234);
    rd(16'h4005, v); rd(16'h4005, v2);
    chk("R8 status while busy", v & 16'hFFBF, 16'h0080);
    chk("R8 bit6 toggles", {15'b0, v[6] ^ v2[6]}, 16'h0001);
    unlock(8'h90);
    wait_busy();
    rd(16'h0000, v); chk("R8 writes during busy ignored", v, 16'hFFFF);
    rd(16'h4005, v); chk("R7 programmed word", v, model[mi(16'h4005)]);

    unlock(8'hA0); wr(16'h8010, 16'h0000);
    rd(16'h8010, v); chk("R7 protected program dropped", v, 16'hFFFF);

    unlock(8'hA0); wr(16'h4005, 16'h1235); e = model_pgm(16'h4005, 16'h1235);
    wait_busy();
    rd(16'h4005, v); chk("R9 error status", v & 16'hFFBF, st_exp(16'h1235, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    rd(16'h0000, v); chk("R9 error sticky", v & 16'hFFBF, st_exp(16'h1235, 1'b1, 1'b0));
    wr(16'h0000, 16'h00F0);
    rd(16'h4005, v); chk("R9 R4 reset clears error", v, model[mi(16'h4005)]);

    unlock(8'h20);
    wr(16'h0000, 16'h00A0); wr(16'h0101, 16'h00FF); e = model_pgm(16'h0101, 16'h00FF);
    wait_busy();
    rd(16'h0101, v); chk("R10 bypass program", v, 16'h00FF);
    wr(16'h0555, 16'h00F0); wr(16'h0123, 16'h0033);
    wr(16'h0ABC, 16'h00A0); wr(16'h0102, 16'h0F0F); e = model_pgm(16'h0102, 16'h0F0F);
    wait_busy();
    rd(16'h0102, v); chk("R10 other writes ignored in bypass", v, 16'h0F0F);
    wr(16'h0000, 16'h00A0); wr(16'h0101, 16'h01FF); e = model_pgm(16'h0101, 16'h01FF);
    wait_busy();
    rd(16'h0101, v); chk("R11 bypass error status", v & 16'hFFBF, st_exp(16'h01FF, 1'b1, 1'b0));
    wr(16'h0000, 16'h00F0);
    wr(16'h0000, 16'h00A0); wr(16'h0104, 16'h00F0); e = model_pgm(16'h0104, 16'h00F0);
    wait_busy();
    rd(16'h0104, v); chk("R11 reset keeps bypass", v, 16'h00F0);
    wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000);
    wr(16'h0000, 16'h00A0); wr(16'h0103, 16'h0000);
    rd(16'h0103, v); chk("R11 bypass exit to read", v, 16'hFFFF);

    for (int it = 0; it < 40; it++) begin
      logic byp;
      if ($urandom_range(0, 3) == 0) prot = 5'($urandom);
      a = 16'($urandom); d = 16'($urandom);
      if ($urandom_range(0, 1) == 1) d = d | model[mi(a)];
      byp = 1'($urandom);
      if (byp) begin
        unlock(8'h20); wr(16'($urandom), {8'($urandom), 8'hA0}); wr(a, d);
      end else begin
        unlock(8'hA0); wr(a, d);
      end
      e = model_pgm(a, d);
      wait_busy();
      if (e) begin
        rd(a, v); chk("R9 random error status", v & 16'hFFBF, st_exp(d, 1'b1, 1'b0));
        wr(16'($urandom), 16'h00F0);
      end
      if (byp) begin wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000); end
      rd(a, v); chk("R7 R10 random program", v, model[mi(a)]);
      rd(a ^ 16'h0800, v); chk("R1 random alias read", v, model[mi(a ^ 16'h0800)]);
    end

    summary();
  end
endmodule